// File: doc/BRIEF.md
# Address-Decoded Letter-Case Conversion Engine

This block is the function side of a small test peripheral on an expansion bus. It sees two kinds of host access: single I/O accesses and byte-wide memory accesses. Each address is matched against two live window bases that come from the configuration logic. Window 0 is a one-location I/O window that holds the operation code. Window 1 is a 256-byte memory window onto a text buffer. The windows are checked in ascending order, and the first one that matches decides the access. For each memory access the block also reports how many bytes the host may touch from that point. That figure is the requested length clamped so the access stays inside the buffer.

Software starts a conversion with a one-cycle apply strobe, a start offset and a length. The engine then walks the buffer one byte per clock. Lowercase, uppercase or swap case is applied to ASCII letters, using the operation code captured with the strobe. A one-cycle done pulse marks the end of the walk. While the walk runs, host memory writes are held off and further apply strobes are ignored.

Top module: `case_text_engine`

## Requirements
- R1: After reset the operation code is 0, busy_o and done_o are low, and the buffer is not being walked.
- R2: A window base is its register value with bit 0 cleared. An address hits a window when base <= address < base + size, with size 1 for window 0 and 256 for window 1. The offset is address minus base.
- R3: Windows are searched from window 0 upward and the first hit wins. A memory access whose address also falls in window 0 is not served by the buffer: mem_hit_o stays low and nothing is written.
- R4: An I/O write that hits window 0 at offset 0 loads io_wdata_i[7:0] into the operation code. An I/O read there returns io_wdata_i with bits 7:0 replaced by the operation code. Any other I/O access returns io_wdata_i unchanged and changes nothing.
- R5: I/O accesses act only when cmd_io_en_i is high, and memory accesses only when cmd_mem_en_i is high. Otherwise io_hit_o and mem_hit_o stay low and no state changes.
- R6: On a memory hit, mem_grant_o equals the smaller of mem_len_i and 256 minus the offset. With no hit it is 0.
- R7: Operation code 0 turns 'A'..'Z' (0x41..0x5A) into 'a'..'z' (0x61..0x7A) and leaves every other byte unchanged.
- R8: Operation code 1 turns 'a'..'z' into 'A'..'Z' and leaves every other byte unchanged.
- R9: Operation code 2 makes uppercase letters lowercase and lowercase letters uppercase. Bytes that are not letters are left unchanged.
- R10: An operation code of 3 or higher leaves the buffer unchanged.
- R11: An accepted apply walks min(apply_len_i, 256 - apply_off_i) bytes starting at apply_off_i, one per clock. busy_o is high for exactly that many cycles, done_o pulses for one cycle after the last byte, and bytes outside the range are untouched.
- R12: While busy_o is high, a host memory write that hits the buffer raises mem_stall_o and is not performed. An apply strobe at the same time is ignored.
- R13: An apply whose clamped length is zero raises done_o for one cycle in the next cycle and never raises busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_io_en_i | input | 1 | I/O space enable from the command register |
| cmd_mem_en_i | input | 1 | Memory space enable from the command register |
| bar0_i | input | 32 | Window 0 base register (bit 0 is the space flag) |
| bar1_i | input | 32 | Window 1 base register (bit 0 is the space flag) |
| io_req_i | input | 1 | I/O access valid |
| io_we_i | input | 1 | I/O access is a write |
| io_addr_i | input | 32 | I/O address |
| io_wdata_i | input | 32 | Write data, or the prior value for a read |
| io_rdata_o | output | 32 | I/O read data |
| io_hit_o | output | 1 | I/O access hit the operation register |
| mem_req_i | input | 1 | Memory access valid |
| mem_we_i | input | 1 | Memory access is a write |
| mem_addr_i | input | 32 | Memory byte address |
| mem_wdata_i | input | 8 | Memory write byte |
| mem_len_i | input | 9 | Requested access length in bytes |
| mem_rdata_o | output | 8 | Buffer byte at the offset |
| mem_hit_o | output | 1 | Memory access served by the buffer |
| mem_grant_o | output | 9 | Clamped access length |
| mem_stall_o | output | 1 | Memory write held off by an active walk |
| apply_i | input | 1 | Start a conversion walk |
| apply_off_i | input | 8 | Walk start offset |
| apply_len_i | input | 9 | Requested walk length |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle walk completion pulse |

## Verification
The bench goes after the window edges: the last byte inside each window and the first one past it. A design that compares inclusively, or that forgets to clear the space flag, would serve an address that should miss. It also checks overlapping windows, where a design that searches in the wrong order would hand window 0's address to the buffer. Walks are started near the top of the buffer and with zero length. A missing clamp would wrap into offset 0 or overrun, and a wrong counter would be visible as a wrong busy length or a missing done pulse. The bench also writes to the buffer during a walk and reads the byte back afterwards; a missing stall would let the host write corrupt it. Every byte value from 0 to 255 is passed through each operation code, so a letter range that is off by one at '@', '[', '`' or '{' would be caught.

// File: rtl/case_text_pkg.sv
package case_text_pkg;
  localparam logic [7:0] OP_LOWER = 8'd0;
  localparam logic [7:0] OP_UPPER = 8'd1;
  localparam logic [7:0] OP_SWAP  = 8'd2;

  function automatic logic is_upper(input logic [7:0] c);
    return (c >= 8'h41) && (c <= 8'h5A);
  endfunction

  function automatic logic is_lower(input logic [7:0] c);
    return (c >= 8'h61) && (c <= 8'h7A);
  endfunction

  function automatic logic [7:0] conv_byte(input logic [7:0] op, input logic [7:0] c);
    logic [7:0] r;
    r = c;
    unique case (op)
      OP_LOWER: if (is_upper(c)) r = c | 8'h20;
      OP_UPPER: if (is_lower(c)) r = c & 8'hDF;
      OP_SWAP:  if (is_upper(c) || is_lower(c)) r = c ^ 8'h20;
      default:  r = c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bar_match.sv
module bar_match #(
  parameter int AW   = 32,
  parameter int SIZE = 256
) (
  input  logic [AW-1:0] bar_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o
);
  logic [AW-1:0] base;
  logic [AW:0]   lim;

  assign base  = bar_i & ~AW'(1);
  assign lim   = {1'b0, base} + (AW+1)'(SIZE);
  assign hit_o = ({1'b0, addr_i} >= {1'b0, base}) && ({1'b0, addr_i} < lim);
  assign off_o = addr_i - base;
endmodule

// File: rtl/text_buf.sv
module text_buf #(
  parameter int DEPTH = 256,
  localparam int OW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [OW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [OW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [OW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/case_walker.sv
module case_walker
  import case_text_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int OW   = $clog2(DEPTH),
  localparam int LW   = OW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [OW-1:0] off_i,
  input  logic [LW-1:0] len_i,
  input  logic [7:0]    op_i,
  input  logic [7:0]    rdata_i,
  output logic [OW-1:0] ptr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [OW-1:0] ptr_q;
  logic [LW-1:0] cnt_q;
  logic [7:0]    op_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      op_q   <= OP_LOWER;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        ptr_q <= ptr_q + OW'(1);
        cnt_q <= cnt_q - LW'(1);
        if (cnt_q == LW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        ptr_q  <= off_i;
        cnt_q  <= len_i;
        op_q   <= op_i;
        busy_q <= (len_i != '0);
        done_q <= (len_i == '0);
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign we_o    = busy_q;
  assign wdata_o = conv_byte(op_q, rdata_i);
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/case_text_engine.sv
module case_text_engine
  import case_text_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 256,
  parameter int IO_SIZE   = 1,
  localparam int OW       = $clog2(BUF_BYTES),
  localparam int LW       = OW + 1,
  localparam int NBAR     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_io_en_i,
  input  logic          cmd_mem_en_i,
  input  logic [AW-1:0] bar0_i,
  input  logic [AW-1:0] bar1_i,
  input  logic          io_req_i,
  input  logic          io_we_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic [31:0]   io_wdata_i,
  output logic [31:0]   io_rdata_o,
  output logic          io_hit_o,
  input  logic          mem_req_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [7:0]    mem_wdata_i,
  input  logic [LW-1:0] mem_len_i,
  output logic [7:0]    mem_rdata_o,
  output logic          mem_hit_o,
  output logic [LW-1:0] mem_grant_o,
  output logic          mem_stall_o,
  input  logic          apply_i,
  input  logic [OW-1:0] apply_off_i,
  input  logic [LW-1:0] apply_len_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [LW-1:0] BUF_LEN = LW'(BUF_BYTES);

  logic [AW-1:0] bars [NBAR];
  logic [NBAR-1:0] io_hits, mem_hits;
  logic [AW-1:0] io_offs [NBAR];
  logic [AW-1:0] mem_offs [NBAR];

  assign bars[0] = bar0_i;
  assign bars[1] = bar1_i;

  for (genvar g = 0; g < NBAR; g++) begin : g_bar
    localparam int SZ = (g == 0) ? IO_SIZE : BUF_BYTES;
    bar_match #(.AW(AW), .SIZE(SZ)) u_io_match (
      .bar_i(bars[g]), .addr_i(io_addr_i), .hit_o(io_hits[g]), .off_o(io_offs[g])
    );
    bar_match #(.AW(AW), .SIZE(SZ)) u_mem_match (
      .bar_i(bars[g]), .addr_i(mem_addr_i), .hit_o(mem_hits[g]), .off_o(mem_offs[g])
    );
  end

  // first-match search, lowest window wins
  int unsigned io_sel, mem_sel;
  logic io_any, mem_any;
  always_comb begin
    io_any = 1'b0; io_sel = 0;
    mem_any = 1'b0; mem_sel = 0;
    for (int i = 0; i < NBAR; i++) begin
      if (!io_any && io_hits[i]) begin
        io_any = 1'b1; io_sel = i;
      end
      if (!mem_any && mem_hits[i]) begin
        mem_any = 1'b1; mem_sel = i;
      end
    end
  end

  logic io_act, mem_act;
  logic [OW-1:0] mem_off;
  assign io_act  = io_req_i && cmd_io_en_i && io_any && (io_sel == 0) && (io_offs[0] == '0);
  assign mem_act = mem_req_i && cmd_mem_en_i && mem_any && (mem_sel == 1);
  assign mem_off = mem_offs[1][OW-1:0];

  // operation register
  logic [7:0] op_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 op_q <= OP_LOWER;
    else if (io_act && io_we_i)  op_q <= io_wdata_i[7:0];
  end

  assign io_hit_o   = io_act;
  assign io_rdata_o = (io_act && !io_we_i) ? {io_wdata_i[31:8], op_q} : io_wdata_i;

  function automatic logic [LW-1:0] clamp_len(input logic [OW-1:0] off, input logic [LW-1:0] len);
    logic [LW-1:0] room;
    room = BUF_LEN - {1'b0, off};
    return (len < room) ? len : room;
  endfunction

  logic walk_busy, walk_we;
  logic [OW-1:0] walk_ptr;
  logic [7:0] walk_wdata, walk_rdata, host_rdata;

  case_walker #(.DEPTH(BUF_BYTES)) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (apply_i),
    .off_i   (apply_off_i),
    .len_i   (clamp_len(apply_off_i, apply_len_i)),
    .op_i    (op_q),
    .rdata_i (walk_rdata),
    .ptr_o   (walk_ptr),
    .we_o    (walk_we),
    .wdata_o (walk_wdata),
    .busy_o  (walk_busy),
    .done_o  (done_o)
  );

  logic host_we;
  assign host_we     = mem_act && mem_we_i && !walk_busy;
  assign mem_stall_o = mem_act && mem_we_i && walk_busy;

  text_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk_i     (clk_i),
    .we_i      (walk_we || host_we),
    .waddr_i   (walk_we ? walk_ptr : mem_off),
    .wdata_i   (walk_we ? walk_wdata : mem_wdata_i),
    .raddr_a_i (walk_ptr),
    .rdata_a_o (walk_rdata),
    .raddr_b_i (mem_off),
    .rdata_b_o (host_rdata)
  );

  assign mem_hit_o   = mem_act;
  assign mem_rdata_o = mem_act ? host_rdata : 8'h00;
  assign mem_grant_o = mem_act ? clamp_len(mem_off, mem_len_i) : '0;
  assign busy_o      = walk_busy;
endmodule

// File: rtl/case_text_engine_chk.sv
module case_text_engine_chk #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 256,
  localparam int LW       = $clog2(BUF_BYTES) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_io_en_i,
  input logic          cmd_mem_en_i,
  input logic          io_hit_o,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic          mem_hit_o,
  input logic [LW-1:0] mem_len_i,
  input logic [LW-1:0] mem_grant_o,
  input logic          mem_stall_o,
  input logic          apply_i,
  input logic          busy_o,
  input logic          done_o
);
  a_r1_idle_after_reset: assert property (@(posedge clk_i) $rose(rst_ni) |-> !busy_o && !done_o);

  a_r5_io_gate: assert property (@(posedge clk_i) disable iff (!rst_ni) !cmd_io_en_i |-> !io_hit_o);

  a_r5_mem_gate: assert property (@(posedge clk_i) disable iff (!rst_ni) !cmd_mem_en_i |-> !mem_hit_o);

  a_r6_grant_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o |-> (mem_grant_o <= mem_len_i) && (mem_grant_o <= LW'(BUF_BYTES)));

  a_r6_grant_miss: assert property (@(posedge clk_i) disable iff (!rst_ni) !mem_hit_o |-> mem_grant_o == '0);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);

  a_r11_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> done_o);

  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && done_o));

  a_r12_stall_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_o |-> busy_o && mem_req_i && mem_we_i);

  a_r12_apply_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && apply_i) |=> busy_o || done_o);

  a_r13_zero_len_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && apply_i) |=> busy_o || done_o);
endmodule

bind case_text_engine case_text_engine_chk #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/case_text_engine_test.sv
module case_text_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b1, mem_en = 1'b1;
  logic [31:0] bar0 = 32'h0000_1001, bar1 = 32'h0002_0000;
  logic        io_req = 0, io_we = 0;
  logic [31:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic        io_hit;
  logic        mem_req = 0, mem_we = 0;
  logic [31:0] mem_addr = 0;
  logic [7:0]  mem_wdata = 0, mem_rdata;
  logic [8:0]  mem_len = 0, mem_grant;
  logic        mem_hit, mem_stall;
  logic        apply = 0;
  logic [7:0]  apply_off = 0;
  logic [8:0]  apply_len = 0;
  logic        busy, done;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  case_text_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_io_en_i(io_en), .cmd_mem_en_i(mem_en),
    .bar0_i(bar0), .bar1_i(bar1),
    .io_req_i(io_req), .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_hit_o(io_hit),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .mem_len_i(mem_len), .mem_rdata_o(mem_rdata), .mem_hit_o(mem_hit),
    .mem_grant_o(mem_grant), .mem_stall_o(mem_stall),
    .apply_i(apply), .apply_off_i(apply_off), .apply_len_i(apply_len),
    .busy_o(busy), .done_o(done)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_conv(input logic [7:0] op, input logic [7:0] c);
    bit up, lo;
    up = (c >= "A" && c <= "Z");
    lo = (c >= "a" && c <= "z");
    if (op == 0 && up) return c + 8'd32;
    if (op == 1 && lo) return c - 8'd32;
    if (op == 2 && up) return c + 8'd32;
    if (op == 2 && lo) return c - 8'd32;
    return c;
  endfunction

  task automatic idle();
    @(negedge clk);
    io_req = 0; io_we = 0; mem_req = 0; mem_we = 0; apply = 0;
  endtask

  task automatic io_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    io_req = 1; io_we = 1; io_addr = a; io_wdata = d;
    idle();
  endtask

  task automatic io_read(input logic [31:0] a, input logic [31:0] prior, output logic [31:0] d, output logic h);
    @(negedge clk);
    io_req = 1; io_we = 0; io_addr = a; io_wdata = prior;
    #1; d = io_rdata; h = io_hit;
    idle();
  endtask

  task automatic mem_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_addr = a; mem_wdata = d; mem_len = 1;
    idle();
  endtask

  task automatic mem_read(input logic [31:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_addr = a; mem_len = 1;
    #1; d = mem_rdata; h = mem_hit;
    idle();
  endtask

  task automatic fill_ramp();
    for (int i = 0; i < 256; i++) begin
      mem_write(32'h2_0000 + i, 8'(i));
      model[i] = 8'(i);
    end
  endtask

  task automatic check_buf(input string req);
    logic [7:0] d; logic h;
    for (int i = 0; i < 256; i++) begin
      mem_read(32'h2_0000 + i, d, h);
      chk(h && d == model[i], req, {23'd0, h, d}, {24'd1, model[i]});
    end
  endtask

  // pulse apply, then count busy cycles until done
  task automatic run_apply(input logic [7:0] off, input logic [8:0] len, output int nbusy, output bit got_done);
    @(negedge clk);
    apply = 1; apply_off = off; apply_len = len;
    @(negedge clk);
    apply = 0;
    nbusy = 0; got_done = 0;
    for (int k = 0; k < 300 && !got_done; k++) begin
      if (done) got_done = 1;
      else begin
        if (busy) nbusy++;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d; logic h;
    #1;
    chk(!busy && !done, "R1 idle", {30'd0, busy, done}, 0);
    io_read(32'h1000, 32'h0, d, h);
    chk(h && d == 32'h0, "R1 op reset", d, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d; logic h; logic [7:0] b;
    io_read(32'h0FFF, 32'h77, d, h); chk(!h && d == 32'h77, "R2 io below", {31'd0, h}, 0);
    io_read(32'h1001, 32'h77, d, h); chk(!h && d == 32'h77, "R2 io past end", {31'd0, h}, 0);
    mem_read(32'h1_FFFF, b, h);     chk(!h, "R2 mem below", {31'd0, h}, 0);
    mem_read(32'h2_00FF, b, h);     chk(h, "R2 mem last byte", {31'd0, h}, 1);
    mem_read(32'h2_0100, b, h);     chk(!h, "R2 mem past end", {31'd0, h}, 0);
  endtask

  task automatic t_io_op();
    logic [31:0] d; logic h;
    io_write(32'h1000, 32'hFFFF_FF5A);
    io_read(32'h1000, 32'hABCD_EF00, d, h);
    chk(h && d == 32'hABCD_EF5A, "R4 op readback", d, 32'hABCD_EF5A);
    io_write(32'h1004, 32'h11);
    io_read(32'h1000, 32'h0, d, h);
    chk(d == 32'h5A, "R4 miss write ignored", d, 32'h5A);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic h; logic [7:0] b;
    io_en = 0;
    io_write(32'h1000, 32'h01);
    io_read(32'h1000, 32'hAA00, d, h);
    chk(!h && d == 32'hAA00, "R5 io disabled", d, 32'hAA00);
    io_en = 1;
    io_read(32'h1000, 32'h0, d, h);
    chk(d == 32'h5A, "R5 op kept", d, 32'h5A);
    mem_write(32'h2_0010, 8'h41); model[16] = 8'h41;
    mem_en = 0;
    mem_write(32'h2_0010, 8'h99);
    mem_read(32'h2_0010, b, h);
    chk(!h, "R5 mem disabled hit", {31'd0, h}, 0);
    mem_en = 1;
    mem_read(32'h2_0010, b, h);
    chk(b == 8'h41, "R5 mem write blocked", b, 8'h41);
  endtask

  task automatic t_grant();
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_addr = 32'h2_0000; mem_len = 9'd300; #1;
    chk(mem_grant == 9'd256, "R6 full window", mem_grant, 256);
    mem_addr = 32'h2_00F0; mem_len = 9'h20; #1;
    chk(mem_grant == 9'h10, "R6 tail clamp", mem_grant, 16);
    mem_addr = 32'h2_0010; mem_len = 9'd5; #1;
    chk(mem_grant == 9'd5, "R6 short", mem_grant, 5);
    mem_addr = 32'h3_0000; #1;
    chk(mem_grant == 0, "R6 miss", mem_grant, 0);
    idle();
  endtask

  task automatic t_op(input logic [7:0] op, input string req);
    int nb; bit gd;
    fill_ramp();
    io_write(32'h1000, {24'd0, op});
    run_apply(8'd0, 9'd256, nb, gd);
    chk(gd && nb == 256, req, nb, 256);
    for (int i = 0; i < 256; i++) model[i] = ref_conv(op, model[i]);
    check_buf(req);
  endtask

  task automatic t_tail_walk();
    int nb; bit gd;
    fill_ramp();
    io_write(32'h1000, 32'h1);
    run_apply(8'hF8, 9'd20, nb, gd);
    chk(gd && nb == 8, "R11 clamped walk length", nb, 8);
    for (int i = 248; i < 256; i++) model[i] = ref_conv(8'd1, model[i]);
    check_buf("R11 range only");
  endtask

  task automatic t_stall();
    int nb; bit st;
    fill_ramp();
    io_write(32'h1000, 32'h2);
    @(negedge clk);
    apply = 1; apply_off = 8'h60; apply_len = 9'd32;
    @(negedge clk);
    apply = 1; apply_off = 8'h00; apply_len = 9'd100;
    mem_req = 1; mem_we = 1; mem_addr = 32'h2_0005; mem_wdata = 8'hEE; #1;
    st = mem_stall;
    chk(st, "R12 stall raised", {31'd0, st}, 1);
    idle();
    nb = 1;
    while (!done) begin
      if (busy) nb++;
      @(negedge clk);
    end
    chk(nb == 32, "R12 second apply ignored", nb, 32);
    for (int i = 96; i < 128; i++) model[i] = ref_conv(8'd2, model[i]);
    check_buf("R12 buffer after stall");
  endtask

  task automatic t_zero();
    @(negedge clk);
    apply = 1; apply_off = 8'h10; apply_len = 9'd0;
    @(negedge clk);
    apply = 0;
    chk(done && !busy, "R13 zero len done", {30'd0, busy, done}, 1);
    @(negedge clk);
    chk(!done && !busy, "R13 single pulse", {30'd0, busy, done}, 0);
  endtask

  task automatic t_priority();
    logic [7:0] b; logic h;
    bar1 = 32'h0000_1000;
    mem_write(32'h1000, 8'h55);
    mem_read(32'h1000, b, h);
    chk(!h, "R3 window 0 first", {31'd0, h}, 0);
    mem_read(32'h1001, b, h);
    chk(h && b == model[1], "R3 buffer byte 1 kept", b, model[1]);
    mem_read(32'h1000 + 32'd255, b, h);
    chk(h, "R3 window 1 hit", {31'd0, h}, 1);
    bar1 = 32'h0002_0000;
    mem_read(32'h2_0000, b, h);
    chk(b == model[0], "R3 byte 0 untouched", b, model[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_io_op();
    t_enable();
    t_grant();
    t_op(8'd0, "R7 lower");
    t_op(8'd1, "R8 upper");
    t_op(8'd2, "R9 swap");
    t_op(8'd7, "R10 no-op code");
    t_tail_walk();
    t_stall();
    t_zero();
    t_priority();
    finish_run();
  end
endmodule